// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block carries a 32-bit RISC core into its exception handlers. Every cycle it looks at three request sources: a non-maskable interrupt, a general exception with a 12-bit event code, and a maskable interrupt with a priority level and its own event code. It accepts at most one of them. On the clock edge after an accepted request it does four things at once:

- It latches the core's current program counter and status word into save registers.
- It raises the privilege, register-bank and block bits in the outgoing status word.
- It records the event code.
- It pulses a redirect strobe together with the handler address, which is the vector base plus an offset chosen by the kind of entry.

An active-low power-on reset does the following:

- It clears the event register and the vector base.
- It presents the boot address and the boot status word.
- It drives a two-bit reset indication high for as long as the reset input is low.

The vector base is loaded through a simple write port. The core applies `new_pc` and `new_sr` in the cycle in which `redirect` is high.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs hold these values: `exp_event` = 0, `vbr_out` = 0, `new_pc` = 0xA0000000, `new_sr` = 0x700000F0 (MD, RB and BL set, mask bits 7:4 = 1111), `redirect` = 0 and `rst_status` = 2'b11. `rst_status` is 2'b00 once `rst_n` is high.
- R2: When a request is accepted at a rising edge, `redirect` is 1 after that edge. On the same edge `saved_pc` and `saved_sr` take the values that `cur_pc` and `cur_sr` had before the edge.
- R3: `new_sr` after an entry equals the sampled `cur_sr` with bit 30 (MD), bit 29 (RB) and bit 28 (BL) set. All other bits are unchanged.
- R4: An accepted general exception writes `gen_code` into `exp_event[11:0]`. `exp_event[31:12]` is always 0. Interrupt entries leave `exp_event` unchanged.
- R5: `new_pc` is VBR+0x100 for a general exception with `tlb_miss`=0, VBR+0x400 with `tlb_miss`=1, and VBR+0x600 for NMI and maskable interrupts. VBR here is the value held before the edge, even when `vbr_we` is high in the same cycle.
- R6: While `cur_sr[28]` (BL) is 1, general exceptions and maskable interrupts are not accepted. In that case `redirect` stays 0 and the new and saved registers and `exp_event` are unchanged.
- R7: NMI is accepted while BL is 1 only when `blmsk_en` is 1. While BL is 0 it is always accepted.
- R8: A maskable interrupt is accepted only when `irq_level` is strictly greater than `cur_sr[7:4]`. An equal level is refused.
- R9: When several requests are accepted together, NMI wins over a general exception, which wins over a maskable interrupt. Only one entry is taken per cycle.
- R10: An NMI entry writes the parameter `NMI_EVENT` (default 0x1C0) into `int_event[11:0]`. An interrupt entry writes `irq_code` there. `int_event[31:12]` is 0.
- R11: `vbr_we`=1 loads `vbr_wdata`, which appears on `vbr_out` after the edge.
- R12: After an edge at which no request was accepted, `redirect` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| gen_req | input | 1 | General exception request |
| gen_code | input | 12 | General exception event code |
| tlb_miss | input | 1 | The general exception is a TLB-miss trap |
| nmi_req | input | 1 | Non-maskable interrupt request |
| blmsk_en | input | 1 | Lets NMI through while BL is set |
| irq_req | input | 1 | Maskable interrupt request |
| irq_level | input | 4 | Maskable interrupt priority level |
| irq_code | input | 12 | Maskable interrupt event code |
| cur_pc | input | 32 | Core's current program counter |
| cur_sr | input | 32 | Core's current status word |
| vbr_we | input | 1 | Vector base write enable |
| vbr_wdata | input | 32 | Vector base write data |
| redirect | output | 1 | One-cycle strobe: apply new_pc/new_sr |
| new_pc | output | 32 | Handler address (boot address in reset) |
| new_sr | output | 32 | Status word for the handler |
| saved_pc | output | 32 | Saved program counter |
| saved_sr | output | 32 | Saved status word |
| exp_event | output | 32 | General exception event register |
| int_event | output | 32 | Interrupt event register |
| vbr_out | output | 32 | Current vector base |
| rst_status | output | 2 | Both bits high while in reset |

## Verification
Every entry result appears exactly one rising edge after the cycle in which its request was presented:

- `redirect`, the new and saved registers, both event registers and a written vector base all change after that edge.
- `rst_status` and the reset values follow `rst_n` without waiting for a clock.

The bench drives each stimulus at a falling edge and pushes the expected outputs for the following rising edge into a queue. A monitor pops one item 2 ns after each rising edge and compares every output, so each comparison lands in the cycle where the result is due. The reset values are checked while `rst_n` is still low.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int unsigned XLEN     = 32;
  localparam int unsigned SR_MD    = 30;
  localparam int unsigned SR_RB    = 29;
  localparam int unsigned SR_BL    = 28;
  localparam int unsigned SR_IM_LO = 4;
  localparam int unsigned IM_W     = 4;

  localparam logic [XLEN-1:0] BOOT_PC  = 32'hA000_0000;
  localparam logic [XLEN-1:0] OFS_GEN  = 32'h0000_0100;
  localparam logic [XLEN-1:0] OFS_TLB  = 32'h0000_0400;
  localparam logic [XLEN-1:0] OFS_INTR = 32'h0000_0600;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_NMI  = 2'd1,
    CLS_GEN  = 2'd2,
    CLS_IRQ  = 2'd3
  } exc_cls_e;

  // Status word handed to a handler: privilege, bank and block raised.
  function automatic logic [XLEN-1:0] entry_sr(input logic [XLEN-1:0] sr);
    logic [XLEN-1:0] r;
    r        = sr;
    r[SR_MD] = 1'b1;
    r[SR_RB] = 1'b1;
    r[SR_BL] = 1'b1;
    return r;
  endfunction

  // Status word presented at power-on.
  function automatic logic [XLEN-1:0] boot_sr();
    logic [XLEN-1:0] r;
    r = '0;
    r[SR_MD] = 1'b1;
    r[SR_RB] = 1'b1;
    r[SR_BL] = 1'b1;
    r[SR_IM_LO +: IM_W] = '1;
    return r;
  endfunction

  // Vector offset chosen by the entry class.
  function automatic logic [XLEN-1:0] vec_offset(input exc_cls_e cls, input logic tlb);
    logic [XLEN-1:0] r;
    case (cls)
      CLS_GEN:          r = tlb ? OFS_TLB : OFS_GEN;
      CLS_NMI, CLS_IRQ: r = OFS_INTR;
      default:          r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic            sr_bl,
  input  logic [IM_W-1:0] sr_imask,
  input  logic            blmsk_en,
  input  logic            nmi_req,
  input  logic            gen_req,
  input  logic            irq_req,
  input  logic [IM_W-1:0] irq_level,
  output logic            take_nmi,
  output logic            take_gen,
  output logic            take_irq,
  output exc_cls_e        cls
);

  logic nmi_ok, gen_ok, irq_ok;

  always_comb begin
    nmi_ok = nmi_req && (!sr_bl || blmsk_en);
    gen_ok = gen_req && !sr_bl;
    irq_ok = irq_req && !sr_bl && (irq_level > sr_imask);
  end

  // Fixed priority: NMI, then general, then maskable interrupt.
  always_comb begin
    take_nmi = nmi_ok;
    take_gen = gen_ok && !nmi_ok;
    take_irq = irq_ok && !nmi_ok && !gen_ok;
    if (take_nmi)      cls = CLS_NMI;
    else if (take_gen) cls = CLS_GEN;
    else if (take_irq) cls = CLS_IRQ;
    else               cls = CLS_NONE;
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int unsigned EV_W = 12,
  parameter logic [EV_W-1:0] NMI_EVENT = 12'h1C0
) (
  input  exc_cls_e        cls,
  input  logic            tlb_miss,
  input  logic [XLEN-1:0] vbr,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [EV_W-1:0] irq_code,
  output logic [XLEN-1:0] tgt_pc,
  output logic [XLEN-1:0] tgt_sr,
  output logic [EV_W-1:0] int_code
);

  always_comb begin
    tgt_pc   = vbr + vec_offset(cls, tlb_miss);
    tgt_sr   = entry_sr(cur_sr);
    int_code = (cls == CLS_NMI) ? NMI_EVENT : irq_code;
  end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_entry_pkg::*;
#(
  parameter int unsigned EV_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_any,
  input  logic            take_gen,
  input  logic            take_int,
  input  logic [XLEN-1:0] tgt_pc,
  input  logic [XLEN-1:0] tgt_sr,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] cur_sr,
  input  logic [EV_W-1:0] gen_code,
  input  logic [EV_W-1:0] int_code,
  input  logic            vbr_we,
  input  logic [XLEN-1:0] vbr_wdata,
  output logic            redirect_q,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] sr_q,
  output logic [XLEN-1:0] spc_q,
  output logic [XLEN-1:0] ssr_q,
  output logic [EV_W-1:0] exp_q,
  output logic [EV_W-1:0] int_q,
  output logic [XLEN-1:0] vbr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_q <= 1'b0;
      pc_q       <= BOOT_PC;
      sr_q       <= boot_sr();
      spc_q      <= '0;
      ssr_q      <= '0;
      exp_q      <= '0;
      int_q      <= '0;
      vbr_q      <= '0;
    end else begin
      redirect_q <= take_any;
      if (take_any) begin
        pc_q  <= tgt_pc;
        sr_q  <= tgt_sr;
        spc_q <= cur_pc;
        ssr_q <= cur_sr;
      end
      if (take_gen) exp_q <= gen_code;
      if (take_int) int_q <= int_code;
      if (vbr_we)   vbr_q <= vbr_wdata;
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned EV_W = 12,
  parameter logic [EV_W-1:0] NMI_EVENT = 12'h1C0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_req,
  input  logic [EV_W-1:0]  gen_code,
  input  logic             tlb_miss,
  input  logic             nmi_req,
  input  logic             blmsk_en,
  input  logic             irq_req,
  input  logic [IM_W-1:0]  irq_level,
  input  logic [EV_W-1:0]  irq_code,
  input  logic [XLEN-1:0]  cur_pc,
  input  logic [XLEN-1:0]  cur_sr,
  input  logic             vbr_we,
  input  logic [XLEN-1:0]  vbr_wdata,
  output logic             redirect,
  output logic [XLEN-1:0]  new_pc,
  output logic [XLEN-1:0]  new_sr,
  output logic [XLEN-1:0]  saved_pc,
  output logic [XLEN-1:0]  saved_sr,
  output logic [XLEN-1:0]  exp_event,
  output logic [XLEN-1:0]  int_event,
  output logic [XLEN-1:0]  vbr_out,
  output logic [1:0]       rst_status
);

  localparam int unsigned EV_PAD = XLEN - EV_W;

  // Named internal events, observed by the checker.
  logic            take_nmi, take_gen, take_irq, take_any, take_int;
  exc_cls_e        cls;
  logic [XLEN-1:0] tgt_pc, tgt_sr, vbr_q;
  logic [EV_W-1:0] int_code, exp_q, int_q;

  exc_arbiter u_arb (
    .sr_bl     (cur_sr[SR_BL]),
    .sr_imask  (cur_sr[SR_IM_LO +: IM_W]),
    .blmsk_en  (blmsk_en),
    .nmi_req   (nmi_req),
    .gen_req   (gen_req),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .take_nmi  (take_nmi),
    .take_gen  (take_gen),
    .take_irq  (take_irq),
    .cls       (cls)
  );

  assign take_int = take_nmi | take_irq;
  assign take_any = take_int | take_gen;

  exc_vector_gen #(.EV_W(EV_W), .NMI_EVENT(NMI_EVENT)) u_vec (
    .cls      (cls),
    .tlb_miss (tlb_miss),
    .vbr      (vbr_q),
    .cur_sr   (cur_sr),
    .irq_code (irq_code),
    .tgt_pc   (tgt_pc),
    .tgt_sr   (tgt_sr),
    .int_code (int_code)
  );

  exc_state_regs #(.EV_W(EV_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_any   (take_any),
    .take_gen   (take_gen),
    .take_int   (take_int),
    .tgt_pc     (tgt_pc),
    .tgt_sr     (tgt_sr),
    .cur_pc     (cur_pc),
    .cur_sr     (cur_sr),
    .gen_code   (gen_code),
    .int_code   (int_code),
    .vbr_we     (vbr_we),
    .vbr_wdata  (vbr_wdata),
    .redirect_q (redirect),
    .pc_q       (new_pc),
    .sr_q       (new_sr),
    .spc_q      (saved_pc),
    .ssr_q      (saved_sr),
    .exp_q      (exp_q),
    .int_q      (int_q),
    .vbr_q      (vbr_q)
  );

  assign exp_event  = {{EV_PAD{1'b0}}, exp_q};
  assign int_event  = {{EV_PAD{1'b0}}, int_q};
  assign vbr_out    = vbr_q;
  assign rst_status = {2{~rst_n}};

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nmi_req,
  input logic        blmsk_en,
  input logic [31:0] cur_pc,
  input logic [31:0] cur_sr,
  input logic        redirect,
  input logic [31:0] new_sr,
  input logic [31:0] saved_pc,
  input logic [31:0] exp_event,
  input logic [1:0]  rst_status,
  input logic        take_nmi,
  input logic        take_gen,
  input logic        take_irq
);

  // R1
  reset_status_chk: assert property (@(posedge clk) !rst_n |-> rst_status == 2'b11);

  // R2
  entry_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi || take_gen || take_irq) |=> redirect);

  // R2
  saved_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_nmi || take_gen || take_irq) |=> saved_pc == $past(cur_pc));

  // R3
  entry_sr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> new_sr[30:28] == 3'b111);

  // R4
  event_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exp_event[31:12] == 20'h0);

  // R6
  block_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_sr[28] && !(nmi_req && blmsk_en)) |=> !redirect);

  // R7
  nmi_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && (!cur_sr[28] || blmsk_en)) |-> take_nmi);

  // R9
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_gen, take_irq}));

  // R12
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_nmi || take_gen || take_irq) |=> !redirect);

endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .nmi_req    (nmi_req),
  .blmsk_en   (blmsk_en),
  .cur_pc     (cur_pc),
  .cur_sr     (cur_sr),
  .redirect   (redirect),
  .new_sr     (new_sr),
  .saved_pc   (saved_pc),
  .exp_event  (exp_event),
  .rst_status (rst_status),
  .take_nmi   (take_nmi),
  .take_gen   (take_gen),
  .take_irq   (take_irq)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_req = 1'b0, tlb_miss = 1'b0, nmi_req = 1'b0, blmsk_en = 1'b0;
  logic        irq_req = 1'b0, vbr_we = 1'b0;
  logic [11:0] gen_code = '0, irq_code = '0;
  logic [3:0]  irq_level = '0;
  logic [31:0] cur_pc = '0, cur_sr = '0, vbr_wdata = '0;
  logic        redirect;
  logic [31:0] new_pc, new_sr, saved_pc, saved_sr, exp_event, int_event, vbr_out;
  logic [1:0]  rst_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic        redir;
    logic [31:0] pc, sr, spc, ssr, ev, iv, vbr;
    string       tag;
  } item_t;

  item_t sb[$];

  // Bench model state.
  logic [31:0] m_pc, m_sr, m_spc, m_ssr, m_ev, m_iv, m_vbr;

  always #4 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .gen_code(gen_code),
    .tlb_miss(tlb_miss), .nmi_req(nmi_req), .blmsk_en(blmsk_en),
    .irq_req(irq_req), .irq_level(irq_level), .irq_code(irq_code),
    .cur_pc(cur_pc), .cur_sr(cur_sr), .vbr_we(vbr_we), .vbr_wdata(vbr_wdata),
    .redirect(redirect), .new_pc(new_pc), .new_sr(new_sr),
    .saved_pc(saved_pc), .saved_sr(saved_sr), .exp_event(exp_event),
    .int_event(int_event), .vbr_out(vbr_out), .rst_status(rst_status)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected result.
  task automatic step(input string tag,
                      input logic g, input logic [11:0] gc, input logic tlb,
                      input logic n, input logic blm,
                      input logic i, input logic [3:0] lvl, input logic [11:0] ic,
                      input logic [31:0] pc, input logic [31:0] sr,
                      input logic we, input logic [31:0] wd);
    item_t it;
    logic  bl, n_ok, g_ok, i_ok;
    int    ofs;
    @(negedge clk);
    gen_req = g; gen_code = gc; tlb_miss = tlb; nmi_req = n; blmsk_en = blm;
    irq_req = i; irq_level = lvl; irq_code = ic; cur_pc = pc; cur_sr = sr;
    vbr_we = we; vbr_wdata = wd;
    bl   = sr[28];
    n_ok = n & (~bl | blm);
    g_ok = g & ~bl & ~n_ok;
    i_ok = i & ~bl & (lvl > sr[7:4]) & ~n_ok & ~g_ok;
    ofs  = g_ok ? (tlb ? 1024 : 256) : 1536;
    if (n_ok | g_ok | i_ok) begin
      m_pc  = m_vbr + ofs;
      m_sr  = sr | 32'h7000_0000;
      m_spc = pc;
      m_ssr = sr;
    end
    if (g_ok) m_ev = {20'h0, gc};
    if (n_ok) m_iv = 32'h1C0;
    if (i_ok) m_iv = {20'h0, ic};
    it.redir = n_ok | g_ok | i_ok;
    it.pc = m_pc; it.sr = m_sr; it.spc = m_spc; it.ssr = m_ssr;
    it.ev = m_ev; it.iv = m_iv;
    if (we) m_vbr = wd;
    it.vbr = m_vbr;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0, 0, 0);
  endtask

  // Monitor: one comparison set per rising edge, 2 ns after it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        chk(e.tag, "redirect", {31'h0, redirect}, {31'h0, e.redir});
        chk(e.tag, "new_pc", new_pc, e.pc);
        chk(e.tag, "new_sr", new_sr, e.sr);
        chk(e.tag, "saved_pc", saved_pc, e.spc);
        chk(e.tag, "saved_sr", saved_sr, e.ssr);
        chk(e.tag, "exp_event", exp_event, e.ev);
        chk(e.tag, "int_event", int_event, e.iv);
        chk(e.tag, "vbr_out", vbr_out, e.vbr);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_pc = 32'hA000_0000; m_sr = 32'h7000_00F0; m_spc = 0; m_ssr = 0;
    m_ev = 0; m_iv = 0; m_vbr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values while rst_n is low
    chk("R1", "rst_status", {30'h0, rst_status}, 32'h3);
    chk("R1", "new_pc", new_pc, 32'hA000_0000);
    chk("R1", "new_sr", new_sr, 32'h7000_00F0);
    chk("R1", "exp_event", exp_event, 32'h0);
    chk("R1", "vbr_out", vbr_out, 32'h0);
    chk("R1", "redirect", {31'h0, redirect}, 32'h0);
    rst_n = 1'b1;
    #1;
    chk("R1", "rst_status released", {30'h0, rst_status}, 32'h0);

    // R11/R12: VBR write, no entry
    step("R11/R12", 0, 0, 0, 0, 0, 0, 0, 0, 32'h100, 32'h0, 1, 32'h8000_0000);
    // R2/R3/R4/R5: general exception, not a TLB miss
    step("R2/R3/R4/R5", 1, 12'h0E0, 0, 0, 0, 0, 0, 0, 32'h0000_1234, 32'h0000_0005, 0, 0);
    // R12: strobe drops
    idle("R12");
    // R5: TLB-miss offset
    step("R5", 1, 12'h040, 1, 0, 0, 0, 0, 0, 32'h0000_2000, 32'h0000_0301, 0, 0);
    // R8/R10: interrupt above mask accepted, exp_event unchanged (R4)
    step("R8/R10/R4", 0, 0, 0, 0, 0, 1, 4'd5, 12'h320, 32'h0000_3000, 32'h0000_0030, 0, 0);
    // R8: equal level refused
    step("R8", 0, 0, 0, 0, 0, 1, 4'd3, 12'h321, 32'h0000_3004, 32'h0000_0030, 0, 0);
    // R6: BL blocks general and interrupt
    step("R6", 1, 12'h0A0, 0, 0, 0, 1, 4'd15, 12'h322, 32'h0000_4000, 32'h1000_0000, 0, 0);
    // R7: NMI blocked by BL without enable
    step("R7", 0, 0, 0, 1, 0, 0, 0, 0, 32'h0000_5000, 32'h1000_0000, 0, 0);
    // R7/R10: NMI through BL with enable
    step("R7/R10", 0, 0, 0, 1, 1, 0, 0, 0, 32'h0000_5004, 32'h1000_0000, 0, 0);
    // R9: all three at once, NMI wins
    step("R9", 1, 12'h0B0, 0, 1, 0, 1, 4'd9, 12'h330, 32'h0000_6000, 32'h0000_0000, 0, 0);
    // R9: general beats interrupt
    step("R9/R4", 1, 12'h0C0, 0, 0, 0, 1, 4'd9, 12'h331, 32'h0000_6100, 32'h0000_0000, 0, 0);
    // R5/R11: VBR write in the same cycle as an entry uses the old base
    step("R5/R11", 1, 12'h0D0, 0, 0, 0, 0, 0, 0, 32'h0000_7000, 32'h0000_0000, 1, 32'h9000_0000);
    // R5: next entry uses the new base, NMI offset
    step("R5/R10", 0, 0, 0, 1, 0, 0, 0, 0, 32'h0000_7100, 32'h0000_0000, 0, 0);
    idle("R12");
    idle("R12");
    @(posedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule